// File: doc/BRIEF.md
# Power Switch Self-Test Engine

This block exercises a power domain's two-stage power switch to find out whether it can be turned on and off reliably. A single start pulse launches a fixed number of on/off cycles. Each turn-on raises the primary enable and then the secondary enable. Each turn-off drops both enables together. After every transition the engine waits a settle time and then checks the two status vectors that come back from the domain. Settle times are counted on a free-running tick input, so the delays are set in nanoseconds through parameters and converted to tick counts when the design is elaborated.

The engine skips the run and reports pass at once when the domain already reads fully on. It refuses to run, and reports an error, when the domain is not isolated at start. It stops at the first wrong status reading, clears both enables and reports fail. Pass and fail are registered results that hold until the next accepted start. The status inputs can pass through an optional synchronizer chain, chosen by a parameter.

Top module: `pst_engine`

## Requirements
- R1: While reset is applied and after it is released, pass, fail, done, error and both switch enables are low.
- R2: If both status vectors read all ones when start is accepted, pass and done rise on the next clock, fail and error stay low, and neither enable is ever asserted. This check is made before the isolation check.
- R3: If start is accepted while the isolation input is low and the domain is not fully on, fail, error and done rise on the next clock and neither enable is asserted.
- R4: In every iteration the primary enable rises exactly one clock before the secondary enable. The secondary enable is never high without the primary enable.
- R5: After both enables are high, the engine waits ON_NS worth of ticks (ceiling of TICK_HZ*ON_NS/1e9). If either status vector is not all ones at that point, it clears both enables and reports fail and done.
- R6: Both enables fall on the same clock. After OFF_NS worth of ticks, the engine reports fail if either status vector still reads all ones. A vector that is only partly set counts as off.
- R7: The engine waits GAP_NS worth of ticks between the end of the off-settle and the next primary enable. After ITERATIONS clean iterations it reports pass and done, with no gap after the last one.
- R8: Pass and fail are never high together. Together with done and error, they hold their values until the next start is accepted. A start pulse during a run is ignored.
- R9: Whenever done is high, both switch enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; accepted only when no run is active |
| tick_i | input | 1 | One-clock timebase pulse at TICK_HZ |
| iso_i | input | 1 | High when the domain's isolation is asserted |
| sta_pri_i | input | STA_W | Status vector of the primary switch stage |
| sta_sec_i | input | STA_W | Status vector of the secondary switch stage |
| en_pri_o | output | 1 | Primary switch enable |
| en_sec_o | output | 1 | Secondary switch enable |
| pass_o | output | 1 | Test passed (held) |
| fail_o | output | 1 | Test failed (held) |
| err_o | output | 1 | Start refused because isolation was low (held, comes with fail) |
| done_o | output | 1 | Result valid (held) |

## Verification
The assertions assume that start is a pulse and that the tick arrives no more often than every other clock. They also assume the status inputs change only in response to the enables, or while the bench is preparing a scenario before start. The bench's power model answers each enable a clock later. It injects a fault only for a chosen iteration, and it changes its force-on or partial-off mode only while the engine is idle with done held. Ticks come every fourth clock, so no zero-count cycle ever coincides with a tick.

// File: rtl/pst_pkg.sv
package pst_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRI_ON,
      ST_SEC_ON,
      ST_ON_WAIT,
      ST_OFF_WAIT,
      ST_GAP_WAIT
   } pst_state_e;

   // ceiling conversion of a nanosecond delay to whole ticks, at least one
   function automatic longint unsigned ns_to_ticks(longint unsigned hz, longint unsigned ns);
      longint unsigned t;
      t = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
      return (t == 0) ? 64'd1 : t;
   endfunction
endpackage

// File: rtl/pst_tick_timer.sv
module pst_tick_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             zero_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= load_val_i;
      else if (tick_i && (cnt_q != '0))
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pst_iter_cnt.sv
module pst_iter_cnt #(
   parameter int unsigned ITERATIONS = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic last_o
);
   localparam int unsigned IW = (ITERATIONS > 1) ? $clog2(ITERATIONS) : 1;
   localparam logic [IW-1:0] LAST = IW'(ITERATIONS - 1);

   logic [IW-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx_q <= '0;
      else if (clr_i)
         idx_q <= '0;
      else if (inc_i && (idx_q != LAST))
         idx_q <= idx_q + 1'b1;
   end

   assign last_o = (idx_q == LAST);
endmodule

// File: rtl/pst_stage_mon.sv
module pst_stage_mon #(
   parameter int unsigned STA_W       = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [STA_W-1:0] sta_i,
   output logic             full_o
);
   logic [STA_W-1:0] sta_s;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign sta_s = sta_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0][STA_W-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else begin
               chain_q[0] <= sta_i;
               for (int k = 1; k < SYNC_STAGES; k++)
                  chain_q[k] <= chain_q[k-1];
            end
         end
         assign sta_s = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   assign full_o = &sta_s;
endmodule

// File: rtl/pst_engine.sv
module pst_engine
   import pst_pkg::*;
#(
   parameter int unsigned STA_W       = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ITERATIONS  = 5,
   parameter int unsigned TICK_HZ     = 1_000_000,
   parameter int unsigned ON_NS       = 5_000,
   parameter int unsigned OFF_NS      = 5_000,
   parameter int unsigned GAP_NS      = 1_000_000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             tick_i,
   input  logic             iso_i,
   input  logic [STA_W-1:0] sta_pri_i,
   input  logic [STA_W-1:0] sta_sec_i,
   output logic             en_pri_o,
   output logic             en_sec_o,
   output logic             pass_o,
   output logic             fail_o,
   output logic             err_o,
   output logic             done_o
);
   localparam longint unsigned ON_T  = ns_to_ticks(64'(TICK_HZ), 64'(ON_NS));
   localparam longint unsigned OFF_T = ns_to_ticks(64'(TICK_HZ), 64'(OFF_NS));
   localparam longint unsigned GAP_T = ns_to_ticks(64'(TICK_HZ), 64'(GAP_NS));
   localparam longint unsigned MAX_T = (ON_T > OFF_T) ? ((ON_T > GAP_T) ? ON_T : GAP_T)
                                                      : ((OFF_T > GAP_T) ? OFF_T : GAP_T);
   localparam int unsigned TMR_W = $clog2(MAX_T + 1);
   localparam int unsigned NSTG  = 2;

   localparam logic [TMR_W-1:0] ON_V  = TMR_W'(ON_T);
   localparam logic [TMR_W-1:0] OFF_V = TMR_W'(OFF_T);
   localparam logic [TMR_W-1:0] GAP_V = TMR_W'(GAP_T);

   generate
      if (STA_W < 1) begin : g_bad_sta
         $error("pst_engine: STA_W must be at least 1");
      end
      if (ITERATIONS < 1) begin : g_bad_iter
         $error("pst_engine: ITERATIONS must be at least 1");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("pst_engine: SYNC_STAGES must be 0 to 4");
      end
      if (TICK_HZ < 1) begin : g_bad_hz
         $error("pst_engine: TICK_HZ must be nonzero");
      end
   endgenerate

   // status monitors, one per switch stage
   logic [NSTG-1:0][STA_W-1:0] sta_in;
   logic [NSTG-1:0]            stg_full;

   assign sta_in[0] = sta_pri_i;
   assign sta_in[1] = sta_sec_i;

   generate
      for (genvar s = 0; s < NSTG; s++) begin : g_stage
         pst_stage_mon #(
            .STA_W       (STA_W),
            .SYNC_STAGES (SYNC_STAGES)
         ) mon_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .sta_i  (sta_in[s]),
            .full_o (stg_full[s])
         );
      end
   endgenerate

   logic all_full, any_full;
   assign all_full = &stg_full;
   assign any_full = |stg_full;

   pst_state_e       state_q;
   logic             tmr_load, tmr_zero;
   logic [TMR_W-1:0] tmr_val;
   logic             it_clr, it_inc, it_last;

   pst_tick_timer #(.CNT_W(TMR_W)) tmr_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .zero_o     (tmr_zero)
   );

   pst_iter_cnt #(.ITERATIONS(ITERATIONS)) iter_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (it_clr),
      .inc_i  (it_inc),
      .last_o (it_last)
   );

   logic run_ok;
   assign run_ok = (state_q == ST_IDLE) && start_i && !all_full && iso_i;

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      it_clr   = run_ok;
      it_inc   = 1'b0;
      unique case (state_q)
         ST_SEC_ON: begin
            tmr_load = 1'b1;
            tmr_val  = ON_V;
         end
         ST_ON_WAIT: begin
            if (tmr_zero && all_full) begin
               tmr_load = 1'b1;
               tmr_val  = OFF_V;
            end
         end
         ST_OFF_WAIT: begin
            if (tmr_zero && !any_full && !it_last) begin
               tmr_load = 1'b1;
               tmr_val  = GAP_V;
               it_inc   = 1'b1;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         en_pri_o <= 1'b0;
         en_sec_o <= 1'b0;
         pass_o   <= 1'b0;
         fail_o   <= 1'b0;
         err_o    <= 1'b0;
         done_o   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  if (all_full) begin
                     pass_o <= 1'b1;
                     fail_o <= 1'b0;
                     err_o  <= 1'b0;
                     done_o <= 1'b1;
                  end else if (!iso_i) begin
                     pass_o <= 1'b0;
                     fail_o <= 1'b1;
                     err_o  <= 1'b1;
                     done_o <= 1'b1;
                  end else begin
                     pass_o  <= 1'b0;
                     fail_o  <= 1'b0;
                     err_o   <= 1'b0;
                     done_o  <= 1'b0;
                     state_q <= ST_PRI_ON;
                  end
               end
            end
            ST_PRI_ON: begin
               en_pri_o <= 1'b1;
               state_q  <= ST_SEC_ON;
            end
            ST_SEC_ON: begin
               en_sec_o <= 1'b1;
               state_q  <= ST_ON_WAIT;
            end
            ST_ON_WAIT: begin
               if (tmr_zero) begin
                  en_pri_o <= 1'b0;
                  en_sec_o <= 1'b0;
                  if (all_full) begin
                     state_q <= ST_OFF_WAIT;
                  end else begin
                     fail_o  <= 1'b1;
                     done_o  <= 1'b1;
                     state_q <= ST_IDLE;
                  end
               end
            end
            ST_OFF_WAIT: begin
               if (tmr_zero) begin
                  if (any_full) begin
                     fail_o  <= 1'b1;
                     done_o  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else if (it_last) begin
                     pass_o  <= 1'b1;
                     done_o  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     state_q <= ST_GAP_WAIT;
                  end
               end
            end
            ST_GAP_WAIT: begin
               if (tmr_zero)
                  state_q <= ST_PRI_ON;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pst_engine_chk.sv
module pst_engine_chk (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic en_pri_o,
   input logic en_sec_o,
   input logic pass_o,
   input logic fail_o,
   input logic err_o,
   input logic done_o
);
   p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(pass_o && fail_o));

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> (done_o && $stable(pass_o) && $stable(fail_o) && $stable(err_o)));

   p_enables_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!en_pri_o && !en_sec_o));

   p_sec_needs_pri_r4: assert property (@(posedge clk) disable iff (!rst_n)
      en_sec_o |-> en_pri_o);

   p_pri_then_sec_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_pri_o) |=> $rose(en_sec_o));

   p_off_together_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_pri_o) |-> $fell(en_sec_o));

   p_err_is_fail_r3: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (fail_o && done_o));
endmodule

bind pst_engine pst_engine_chk chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .en_pri_o (en_pri_o),
   .en_sec_o (en_sec_o),
   .pass_o   (pass_o),
   .fail_o   (fail_o),
   .err_o    (err_o),
   .done_o   (done_o)
);

// File: tb/pst_engine_tb.sv
`timescale 1ns/1ps
module pst_engine_tb_top;
   localparam int STA_W  = 2;
   localparam int ITERS  = 5;
   localparam int ON_TK  = 5;   // 5000 ns at 1 MHz
   localparam int OFF_TK = 2;   // 2000 ns
   localparam int GAP_TK = 50;  // 50000 ns

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic tick_i;
   logic iso_i = 1'b1;
   logic [STA_W-1:0] sta_pri_i, sta_sec_i;
   logic en_pri_o, en_sec_o, pass_o, fail_o, err_o, done_o;

   always #2 clk = ~clk; // 250 MHz

   pst_engine #(
      .STA_W(STA_W), .SYNC_STAGES(2), .ITERATIONS(ITERS), .TICK_HZ(1_000_000),
      .ON_NS(5_000), .OFF_NS(2_000), .GAP_NS(50_000)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_i(tick_i), .iso_i(iso_i),
      .sta_pri_i(sta_pri_i), .sta_sec_i(sta_sec_i), .en_pri_o(en_pri_o), .en_sec_o(en_sec_o),
      .pass_o(pass_o), .fail_o(fail_o), .err_o(err_o), .done_o(done_o)
   );

   // tick every fourth clock
   logic [1:0] tdiv = '0;
   always_ff @(posedge clk) tdiv <= tdiv + 1'b1;
   assign tick_i = (tdiv == 2'd3);

   // power model controls and monitor state
   logic force_on = 1'b0, partial_off = 1'b0;
   int   no_on_iter = -1, stuck_iter = -1;
   int   rises = 0, order_bad = 0, on_bad = 0, win_ticks = 0, gap_ticks = 0;
   int   gap_min = 1000000, gap_max = 0;
   logic prev_pri = 1'b0, prev_sec = 1'b0, pri_rose_prev = 1'b0;
   logic [STA_W-1:0] m_pri = '0, m_sec = '0;

   always_ff @(posedge clk) begin
      if (force_on) begin
         m_pri <= '1;
         m_sec <= '1;
      end else begin
         m_pri <= en_pri_o ? '1 : ((stuck_iter == rises) ? '1 : (partial_off ? 2'b01 : 2'b00));
         m_sec <= (en_sec_o && (no_on_iter != rises)) ? '1 : '0;
      end
   end
   assign sta_pri_i = m_pri;
   assign sta_sec_i = m_sec;

   always @(negedge clk) begin
      if (en_pri_o && !prev_pri) begin
         rises = rises + 1;
         if (rises > 1) begin
            if (gap_ticks < gap_min) gap_min = gap_ticks;
            if (gap_ticks > gap_max) gap_max = gap_ticks;
         end
      end
      if (en_sec_o && !prev_sec && !pri_rose_prev) order_bad = order_bad + 1;
      if (en_sec_o && !en_pri_o) order_bad = order_bad + 1;
      if (en_pri_o != en_sec_o && !(en_pri_o && !prev_pri)) order_bad = order_bad + 1;
      if (en_sec_o && tick_i) win_ticks = win_ticks + 1;
      if (!en_sec_o && prev_sec) begin
         if (win_ticks < ON_TK || win_ticks > ON_TK + 1) on_bad = on_bad + 1;
         win_ticks = 0;
      end
      if (!en_pri_o && prev_pri) gap_ticks = 0;
      else if (!en_pri_o && tick_i) gap_ticks = gap_ticks + 1;
      pri_rose_prev = en_pri_o && !prev_pri;
      prev_pri = en_pri_o;
      prev_sec = en_sec_o;
   end

   int n_chk = 0, n_bad = 0;

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      rises = 0; order_bad = 0; on_bad = 0; win_ticks = 0; gap_ticks = 0;
      gap_min = 1000000; gap_max = 0;
   endtask

   task automatic pulse_start_and_wait(input bool_mid_start);
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      for (int i = 0; i < 20000 && !done_o; i++) begin
         if (bool_mid_start && i == 300) start_i = 1'b1;
         else start_i = 1'b0;
         @(negedge clk);
      end
      start_i = 1'b0;
      chk("R8 run finished", int'(done_o), 1);
   endtask

   task automatic t_reset();
      chk("R1 outputs in reset", int'({en_pri_o, en_sec_o, pass_o, fail_o, err_o, done_o}), 0);
      @(negedge clk) rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R1 outputs after reset", int'({en_pri_o, en_sec_o, pass_o, fail_o, err_o, done_o}), 0);
   endtask

   task automatic t_iso_low();
      clear_mon();
      iso_i = 1'b0;
      pulse_start_and_wait(1'b0);
      chk("R3 fail", int'(fail_o), 1);
      chk("R3 error", int'(err_o), 1);
      chk("R8 pass low with fail", int'(pass_o), 0);
      chk("R3 no enables", rises, 0);
      iso_i = 1'b1;
   endtask

   task automatic t_already_on();
      clear_mon();
      force_on = 1'b1;
      iso_i = 1'b0;
      repeat (8) @(negedge clk);
      pulse_start_and_wait(1'b0);
      chk("R2 pass", int'(pass_o), 1);
      chk("R2 no error", int'(err_o | fail_o), 0);
      chk("R2 no enables", rises, 0);
      force_on = 1'b0;
      iso_i = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   task automatic t_normal();
      clear_mon();
      pulse_start_and_wait(1'b1);
      chk("R7 pass", int'(pass_o), 1);
      chk("R8 fail low with pass", int'(fail_o), 0);
      chk("R7 iteration count", rises, ITERS);
      chk("R4 enable order", order_bad, 0);
      chk("R5 on settle window", on_bad, 0);
      chk("R7 gap min ok", int'(gap_min >= OFF_TK + GAP_TK && gap_min <= OFF_TK + GAP_TK + 2), 1);
      chk("R7 gap max ok", int'(gap_max <= OFF_TK + GAP_TK + 2), 1);
      chk("R9 enables low at done", int'({en_pri_o, en_sec_o}), 0);
      repeat (40) @(negedge clk);
      chk("R8 result held", int'({pass_o, fail_o, done_o}), 3'b101);
   endtask

   task automatic t_sec_stuck_off();
      clear_mon();
      no_on_iter = 3;
      pulse_start_and_wait(1'b0);
      chk("R5 fail on missing secondary", int'(fail_o), 1);
      chk("R5 stopped at iteration", rises, 3);
      chk("R9 enables cleared on fail", int'({en_pri_o, en_sec_o}), 0);
      chk("R5 no error", int'(err_o | pass_o), 0);
      no_on_iter = -1;
   endtask

   task automatic t_pri_stuck_on();
      clear_mon();
      stuck_iter = 2;
      pulse_start_and_wait(1'b0);
      chk("R6 fail on stuck primary", int'(fail_o), 1);
      chk("R6 stopped at iteration", rises, 2);
      stuck_iter = -1;
      repeat (8) @(negedge clk);
   endtask

   task automatic t_partial_off();
      clear_mon();
      partial_off = 1'b1;
      repeat (8) @(negedge clk);
      pulse_start_and_wait(1'b0);
      chk("R6 partial reading counts as off", int'(pass_o), 1);
      chk("R6 all iterations run", rises, ITERS);
      partial_off = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_iso_low();
      t_already_on();
      t_normal();
      t_sec_stuck_off();
      t_pri_stuck_on();
      t_partial_off();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule